// File: doc/BRIEF.md
# Per-Channel LED Output Selector

This block sits between a bank of LED mode registers and sixteen open-drain pads. Every pad owns a 2-bit mode code. The code chooses one of four behaviours: the pad is pulled to ground, the pad is left floating, or the pad copies one of two shared blink waveforms. The result is a per-pad drive-low enable, which is registered once before it reaches the pad cell.

The block also reports the level seen at every pad, whatever that pad is being told to do. This lets any channel serve as a general purpose input or output. A pad that is released reads back through the external pull-up or the external driver. The pad levels pass through a two-flop synchroniser and are presented as two bytes, lower half and upper half. The mode words come from the bus interface. The blink waveforms come from the prescaler and duty-cycle logic, and both are in this block's clock domain.

Top module: `led_output_selector`

## Requirements
- R1: A pad whose mode code is 00 has its drive-low enable set to 1 one clock edge after that code is sampled.
- R2: A pad whose mode code is 01 has its drive-low enable at 0 (released) one clock edge after that code is sampled.
- R3: A pad whose mode code is 10 has a drive-low enable equal to the value that `blinkA` had at the previous edge. A high waveform means the LED is on, that is, the pad is pulled low.
- R4: A pad whose mode code is 11 has a drive-low enable equal to the value that `blinkB` had at the previous edge.
- R5: Pad p takes its code from `selWord[2p+1:2p]`. The 32-bit word is the four 8-bit selector bytes concatenated with the byte for pads 0 to 3 lowest, so that inside each byte the lowest pad sits in the lowest two bits. A code on one pad does not affect any other pad.
- R6: While `rstN` is low, every drive-low enable is 0 and both input bytes read 0, whatever the other inputs are.
- R7: `inLow` equals `padIn[7:0]` and `inHigh` equals `padIn[15:8]` as sampled two clock edges earlier. After only one edge, the previous value is still shown.
- R8: The input bytes report the pad levels whatever mode code each pad holds, including pads that are being pulled low or are following a waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selWord | input | 32 | Four selector bytes, 2 bits per pad |
| blinkA | input | 1 | Shared blink waveform 0, high = LED on |
| blinkB | input | 1 | Shared blink waveform 1, high = LED on |
| padIn | input | 16 | Raw level at each pad |
| pullLow | output | 16 | Per-pad drive-low enable for the open-drain cell |
| inLow | output | 8 | Synchronised levels of pads 0 to 7 |
| inHigh | output | 8 | Synchronised levels of pads 8 to 15 |

## Verification
The properties assume that `selWord`, `blinkA` and `blinkB` are produced in the same clock domain and are stable around each rising edge. This lets a pad's output be related to the inputs of exactly one edge earlier. They also assume that `padIn` is steady across the two edges of the synchroniser before its value is compared. The stimulus changes every input only on the falling clock edge. It holds each pad pattern for at least two rising edges before reading the input bytes, and it never drops reset in the middle of a comparison window.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SEL_LOW     = 2'b00,
    SEL_RELEASE = 2'b01,
    SEL_WAVE0   = 2'b10,
    SEL_WAVE1   = 2'b11
  } selCode_e;

  // per-pad strobes handed from the decoder to the datapath
  typedef struct packed {
    logic holdLow;
    logic useWave0;
    logic useWave1;
  } pinStrobe_t;
endpackage

// File: rtl/led_sel_ctrl.sv
module led_sel_ctrl
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [NUM_PINS*CODE_W-1:0] selWord,
  output pinStrobe_t [NUM_PINS-1:0]  strobes
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
    selCode_e code;
    assign code = selCode_e'(selWord[p*CODE_W +: CODE_W]);

    always_comb begin
      strobes[p] = '0;
      case (code)
        SEL_LOW:     strobes[p].holdLow  = 1'b1;
        SEL_WAVE0:   strobes[p].useWave0 = 1'b1;
        SEL_WAVE1:   strobes[p].useWave1 = 1'b1;
        default:     strobes[p] = '0;  // released
      endcase
    end
  end
endmodule

// File: rtl/led_sel_dpath.sv
module led_sel_dpath
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pinStrobe_t [NUM_PINS-1:0] strobes,
  input  logic                      blinkA,
  input  logic                      blinkB,
  input  logic [NUM_PINS-1:0]       padIn,
  output logic [NUM_PINS-1:0]       pullLow,
  output logic [NUM_PINS-1:0]       padLevels
);
  logic [NUM_PINS-1:0] driveNext;
  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mux
    assign driveNext[p] = strobes[p].holdLow
                        | (strobes[p].useWave0 & blinkA)
                        | (strobes[p].useWave1 & blinkB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pullLow <= '0;
    else       pullLow <= driveNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  assign padLevels = syncStage[SYNC_STAGES-1];
endmodule

// File: rtl/led_output_selector.sv
module led_output_selector
  import led_sel_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = NUM_PINS * CODE_W,
  localparam int HALF       = NUM_PINS / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SEL_W-1:0]    selWord,
  input  logic                blinkA,
  input  logic                blinkB,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] pullLow,
  output logic [HALF-1:0]     inLow,
  output logic [HALF-1:0]     inHigh
);
  pinStrobe_t [NUM_PINS-1:0] strobes;
  logic [NUM_PINS-1:0]       padLevels;

  led_sel_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .selWord (selWord),
    .strobes (strobes)
  );

  led_sel_dpath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .blinkA    (blinkA),
    .blinkB    (blinkB),
    .padIn     (padIn),
    .pullLow   (pullLow),
    .padLevels (padLevels)
  );

  assign inLow  = padLevels[HALF-1:0];
  assign inHigh = padLevels[NUM_PINS-1:HALF];
endmodule

// File: rtl/led_sel_chk.sv
module led_sel_chk #(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HALF       = NUM_PINS / 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2*NUM_PINS-1:0] selWord,
  input logic                  blinkA,
  input logic                  blinkB,
  input logic [NUM_PINS-1:0]   padIn,
  input logic [NUM_PINS-1:0]   pullLow,
  input logic [HALF-1:0]       inLow,
  input logic [HALF-1:0]       inHigh
);
  logic [1:0] sinceReset;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    a_r1_pull_low: assert property (@(posedge clk) disable iff (!rstN)
      (selWord[2*p +: 2] == 2'b00) |=> pullLow[p]);
    a_r2_release: assert property (@(posedge clk) disable iff (!rstN)
      (selWord[2*p +: 2] == 2'b01) |=> !pullLow[p]);
    a_r3_wave0: assert property (@(posedge clk) disable iff (!rstN)
      (selWord[2*p +: 2] == 2'b10) |=> (pullLow[p] == $past(blinkA)));
    a_r4_wave1: assert property (@(posedge clk) disable iff (!rstN)
      (selWord[2*p +: 2] == 2'b11) |=> (pullLow[p] == $past(blinkB)));
  end

  a_r6_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (pullLow == '0 && inLow == '0 && inHigh == '0));

  if (SYNC_STAGES == 2) begin : g_sync
    a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
      (sinceReset >= 2'd2) |-> ({inHigh, inLow} == $past(padIn, 2)));
  end
endmodule

bind led_output_selector led_sel_chk #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .selWord (selWord),
  .blinkA  (blinkA),
  .blinkB  (blinkB),
  .padIn   (padIn),
  .pullLow (pullLow),
  .inLow   (inLow),
  .inHigh  (inHigh)
);

// File: tb/tb_led_output_selector.sv
module tb_led_output_selector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] selWord = '0;
  logic        blinkA = 1'b1, blinkB = 1'b1;
  logic [15:0] padIn = 16'hA5C3;
  logic [15:0] pullLow;
  logic [7:0]  inLow, inHigh;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  led_output_selector dut (.*);

  function automatic logic [15:0] expDrive(logic [31:0] s, logic a, logic b);
    logic [15:0] r;
    for (int p = 0; p < 16; p++)
      case (s[2*p +: 2])
        2'b00: r[p] = 1'b1;
        2'b01: r[p] = 1'b0;
        2'b10: r[p] = a;
        default: r[p] = b;
      endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string codeTag(int c);
    case (c)
      0: return "R1 low";
      1: return "R2 release";
      2: return "R3 wave0";
      default: return "R4 wave1";
    endcase
  endfunction

  initial begin
    logic [15:0] prevPad;
    // R6: reset holds everything quiet even with all pads coded low
    repeat (3) @(negedge clk);
    check("R6 drive", {16'h0, pullLow}, 32'h0);
    check("R6 inLow", {24'h0, inLow}, 32'h0);
    check("R6 inHigh", {24'h0, inHigh}, 32'h0);

    rstN = 1'b1;
    selWord = 32'h5555_5555;
    @(negedge clk);
    check("R2 after reset", {16'h0, pullLow}, 32'h0);

    // R1..R4 uniform codes under every waveform combination
    for (int c = 0; c < 4; c++)
      for (int ab = 0; ab < 4; ab++) begin
        selWord = {16{c[1:0]}};
        blinkA = ab[0];
        blinkB = ab[1];
        @(negedge clk);
        check(codeTag(c), {16'h0, pullLow}, {16'h0, expDrive(selWord, blinkA, blinkB)});
      end

    // R5 walking one pad coded low among released pads
    for (int p = 0; p < 16; p++) begin
      selWord = 32'h5555_5555 & ~(32'h3 << (2*p));
      @(negedge clk);
      check("R5 walk", {16'h0, pullLow}, {16'h0, 16'h1 << p});
    end

    // R5 mixed code words
    for (int i = 0; i < 40; i++) begin
      selWord = (i * 32'h9E37_79B9) ^ (i << 7);
      blinkA = i[0];
      blinkB = i[1];
      @(negedge clk);
      check("R5 mixed", {16'h0, pullLow}, {16'h0, expDrive(selWord, blinkA, blinkB)});
    end

    // R7 synchroniser latency
    selWord = 32'h5555_5555;
    @(negedge clk); @(negedge clk);
    prevPad = padIn;
    for (int k = 0; k < 8; k++) begin
      padIn = 16'h1357 * (k + 3) ^ 16'hF00F;
      @(negedge clk);
      check("R7 one edge", {16'h0, inHigh, inLow}, {16'h0, prevPad});
      @(negedge clk);
      check("R7 two edges", {16'h0, inHigh, inLow}, {16'h0, padIn});
      prevPad = padIn;
    end

    // R8 read back while pads are driven or following waveforms
    selWord = 32'h0;
    padIn = 16'hFFFF;
    @(negedge clk); @(negedge clk);
    check("R8 driven low", {16'h0, inHigh, inLow}, 32'hFFFF);
    selWord = 32'hAAAA_FFFF;
    padIn = 16'h5AA5;
    @(negedge clk); @(negedge clk);
    check("R8 waveform", {16'h0, inHigh, inLow}, 32'h5AA5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule